// File: doc/BRIEF.md
# Keypad Tone Code Latch

This block sits behind a dual-tone detector and its steering logic. It takes a detected row tone index and a detected column tone index and turns the pair into a 4-bit key code with a telephone keypad mapping. The code is captured in an output register only when the steering logic sends a one-cycle register strobe. Between tones the register keeps the last code it captured.

The register drives a 4-bit data bus that can be released. The release is modelled as a data output plus one drive-enable bit per lane. An inhibit input blocks any pair that uses the highest column tone, and the register keeps its old code while that happens. Pairs on the other three columns are still captured while inhibit is high.

Row index encoding: 0 = 697 Hz, 1 = 770 Hz, 2 = 852 Hz, 3 = 941 Hz. Column index encoding: 0 = 1209 Hz, 1 = 1336 Hz, 2 = 1477 Hz, 3 = 1633 Hz.

Top module: `tone_code_latch`

## Requirements
- R1: For rows 0..2 and columns 0..2 (keys 1 to 9), a captured pair gives the code 3*row + col + 1, which runs from 0001 to 1001 in reading order.
- R2: On row 3, column 1 (key 0) gives 1010, column 0 (key *) gives 1011 and column 2 (key #) gives 1100.
- R3: On column 3, rows 0, 1, 2 and 3 (keys A, B, C, D) give 1101, 1110, 1111 and 0000.
- R4: When `bus_en` is high, all four `bus_drive` bits are 1 and `bus_data` carries the held code. When `bus_en` is low, all four `bus_drive` bits are 0 (high impedance). `bus_drive` follows `bus_en` in the same cycle, with no register.
- R5: A strobe with column index 3 while `col4_inhibit` is high is ignored, and the held code stays unchanged.
- R6: While `col4_inhibit` is high, strobes on columns 0..2 still update the held code.
- R7: When `reg_strobe` is low, the held code does not change, whatever the row and column inputs do.
- R8: While `rst_n` is low, and right after reset, the held code is 0000.
- R9: A code captured at the clock edge where `reg_strobe` is high appears on `bus_data` after that edge. Strobes on consecutive cycles each take effect.
- R10: `bus_data[3]` is the most significant bit of the code (Q4) and `bus_data[0]` is the least significant bit (Q1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_idx | input | 2 | Detected row tone index |
| col_idx | input | 2 | Detected column tone index |
| reg_strobe | input | 1 | One-cycle strobe: the tone pair has been registered |
| col4_inhibit | input | 1 | Blocks capture of pairs on column 3 |
| bus_en | input | 1 | Output enable for the data bus |
| bus_data | output | 4 | Held key code, MSB = Q4 |
| bus_drive | output | 4 | Per-lane drive enable; 0 means high impedance |

## Verification
A wrong entry in the mapping shows on `bus_data` one cycle after the strobe for that pair, and only for that pair. For that reason, all sixteen pairs are applied and each is compared on the following cycle. A hold or inhibit fault shows as a code change in the cycle after a strobe that should have been blocked, or after a change on row or column with no strobe. A fault in the enable path shows at once on `bus_drive`, with no delay.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 2;
  localparam int CODE_W = 4;

  // Telephone keypad mapping. Row 3 and column 3 are the irregular edges.
  function automatic logic [CODE_W-1:0] pair_to_code(
    input logic [ROW_W-1:0] row,
    input logic [COL_W-1:0] col
  );
    logic [CODE_W-1:0] c;
    if (col == 2'd3) begin
      c = (row == 2'd3) ? 4'd0 : 4'(4'd13 + row);
    end else if (row != 2'd3) begin
      c = 4'(row * 3 + col + 1);
    end else begin
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        default: c = 4'd12;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/tcl_encoder.sv
module tcl_encoder
  import tcl_pkg::*;
(
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COL_W-1:0]  col_idx,
  output logic [CODE_W-1:0] code
);
  always_comb code = pair_to_code(row_idx, col_idx);
endmodule

// File: rtl/tcl_gate.sv
module tcl_gate
  import tcl_pkg::*;
#(
  parameter int INH_COL = 3
) (
  input  logic             reg_strobe,
  input  logic             inhibit,
  input  logic [COL_W-1:0] col_idx,
  output logic             accept
);
  logic blocked;
  always_comb begin
    blocked = inhibit && (col_idx == COL_W'(INH_COL));
    accept  = reg_strobe && !blocked;
  end
endmodule

// File: rtl/tcl_bus_drive.sv
module tcl_bus_drive #(
  parameter int W = 4
) (
  input  logic [W-1:0] held,
  input  logic         en,
  output logic [W-1:0] data,
  output logic [W-1:0] drive
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign data[i]  = held[i];
    assign drive[i] = en;
  end
endmodule

// File: rtl/tone_code_latch.sv
module tone_code_latch
  import tcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COL_W-1:0]  col_idx,
  input  logic              reg_strobe,
  input  logic              col4_inhibit,
  input  logic              bus_en,
  output logic [CODE_W-1:0] bus_data,
  output logic [CODE_W-1:0] bus_drive
);
  localparam int INH_COL = (1 << COL_W) - 1;

  logic [CODE_W-1:0] pair_code;
  logic              accept;
  logic [CODE_W-1:0] held_code;

  tcl_encoder u_enc (
    .row_idx (row_idx),
    .col_idx (col_idx),
    .code    (pair_code)
  );

  tcl_gate #(.INH_COL(INH_COL)) u_gate (
    .reg_strobe (reg_strobe),
    .inhibit    (col4_inhibit),
    .col_idx    (col_idx),
    .accept     (accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_code <= '0;
    else if (accept) held_code <= pair_code;
  end

  tcl_bus_drive #(.W(CODE_W)) u_drv (
    .held  (held_code),
    .en    (bus_en),
    .data  (bus_data),
    .drive (bus_drive)
  );

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_strobe |=> $stable(bus_data)); // R7
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_strobe && col4_inhibit && col_idx == COL_W'(INH_COL)) |=> $stable(bus_data)); // R5
  AST_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bus_data == $past(pair_code)); // R9
  AST_NONZERO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(row_idx == 2'd3 && col_idx == 2'd3)) |=> bus_data != '0); // R1
  AST_DRIVE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive == '0) || (bus_drive == '1)); // R4
endmodule

// File: tb/sim_tone_code_latch.sv
module sim_tone_code_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] row_idx = '0, col_idx = '0;
  logic reg_strobe = 1'b0, col4_inhibit = 1'b0, bus_en = 1'b0;
  logic [3:0] bus_data, bus_drive;

  int vectors = 0, errors = 0;
  int exp_code = 0;
  string tag = "R8";
  bit checking = 0;

  always #2.5 clk = ~clk;

  tone_code_latch u0 (.*);

  // Keypad as characters, row-major; code found from the key label.
  function automatic int key_value(int r, int c);
    string pad = "123A456B789C*0#D";
    byte k = pad[r*4 + c];
    if (k >= "1" && k <= "9") return k - "0";
    case (k)
      "0": return 10;
      "*": return 11;
      "#": return 12;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) exp_code <= 0;
    else if (reg_strobe && !(col4_inhibit && col_idx == 2'd3))
      exp_code <= key_value(row_idx, col_idx);
  end

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (bus_data !== 4'(exp_code)) begin
        errors++;
        $display("FAIL %s: bus_data=%b expected %b", tag, bus_data, 4'(exp_code));
      end
      vectors++;
      if (bus_drive !== {4{bus_en}}) begin
        errors++;
        $display("FAIL R4: bus_drive=%b expected %b", bus_drive, {4{bus_en}});
      end
    end
  end

  task automatic step(input string t, input logic s, input int r, input int c,
                      input logic inh, input logic en);
    @(negedge clk); #1;
    tag = t; reg_strobe = s; row_idx = 2'(r); col_idx = 2'(c);
    col4_inhibit = inh; bus_en = en;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    checking = 1;
    repeat (3) @(negedge clk);            // R8 reset state checked
    #1 rst_n = 1'b1;
    step("R8", 0, 2, 2, 0, 1);
    // R1 R2 R3 R10: every pair, strobe then a quiet cycle
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        step((c == 3) ? "R3" : (r == 3) ? "R2" : "R1", 1, r, c, 0, 1);
        step("R10", 0, 3 - r, 3 - c, 0, 1);
      end
    // R7: inputs wander with no strobe
    step("R7", 1, 1, 1, 0, 1);
    for (int i = 0; i < 8; i++) step("R7", 0, i % 4, (i * 3) % 4, 0, 1);
    // R5: inhibited column 3 strobes ignored
    for (int r = 0; r < 4; r++) begin
      step("R5", 1, r, 3, 1, 1);
      step("R5", 0, r, 3, 1, 1);
    end
    // R6: other columns still load under inhibit
    step("R6", 1, 3, 2, 1, 1);
    step("R6", 0, 0, 0, 1, 1);
    step("R6", 1, 0, 0, 1, 0);
    // R4: enable toggling
    for (int i = 0; i < 6; i++) step("R4", 0, 0, 0, 0, i[0]);
    // R9: back-to-back strobes
    step("R9", 1, 2, 1, 0, 1);
    step("R9", 1, 3, 3, 0, 1);
    step("R9", 1, 1, 3, 0, 1);
    step("R9", 1, 3, 1, 0, 1);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step("R9", 1'($urandom_range(0, 1)), $urandom_range(0, 3),
           $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    step("R7", 0, 0, 0, 0, 1);
    @(negedge clk);
    #1 checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule